// File: doc/BRIEF.md
# Binary Phase-Code Pulse Compressor

This block is a matched filter for a radar pulse whose chips carry a phase of either 0 or π. It takes complex baseband samples from a down-converter and keeps one sample in four, at a selectable phase, so that it works at one sample per chip. It correlates the most recent code-length chips against a stored ±1 reference. Because every weight is +1 or −1, each tap is an add or a subtract, and no multiplier is used. One full-precision complex result comes out per range gate, tagged with the gate number and flagged on the last gate, and goes to a following Doppler stage.

Timing comes from two strobes. A repetition strobe arms a new frame. A transmit-end strobe opens reception once the outgoing pulse is over. The frame then closes by itself after the final gate. A repetition strobe that arrives during a frame throws away the unfinished frame and re-arms it. The reference code is shifted in one bit per load strobe.

Top module: `pc_bpsk_corr`

## Requirements
- R1: While reset is asserted and after it is released, res_valid_o, res_last_o, res_gate_o, res_i_o and res_q_o are all zero until a frame produces a result.
- R2: Each cycle with code_load_i high shifts code_bit_i into the reference. Of the last CODE_LEN bits loaded, the earliest is chip 0, the first chip of the pulse. A bit of 0 weighs +1 and a bit of 1 weighs −1. An echo that matches the code therefore peaks at +CODE_LEN times its amplitude, at the gate where it starts.
- R3: After pri_i, samples are ignored until tx_end_i. Collection starts with the first valid sample after the tx_end_i cycle. A tx_end_i that is not preceded by pri_i in the same frame is ignored.
- R4: Valid samples of a frame are counted from 0, and cycles with smp_valid_i low are not counted. Sample n becomes a chip-rate symbol exactly when n mod 4 equals phase_i.
- R5: With symbols s[m] numbered from 0, gate g reports sum over k of w_k·s[g+k] for I and Q separately. It is exact in IQ_W + ceil(log2 CODE_LEN) signed bits, with no wrap even for full-scale inputs of either sign.
- R6: Each frame yields exactly NUM_GATES results, with gates 0 to NUM_GATES−1 in increasing order.
- R7: res_last_o is high with the result for gate NUM_GATES−1 and with no other result. The frame then ends, and further samples produce nothing until the next pri_i.
- R8: A pri_i during a frame discards the partial frame. No result appears in the following cycle. Gate counting and symbol decimation restart, so the next frame produces a complete, correct set of gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_i | input | 1 | Repetition strobe, arms or re-arms a frame |
| tx_end_i | input | 1 | Transmit-end strobe, opens reception |
| phase_i | input | 2 | Decimation phase, 0 to 3 |
| smp_valid_i | input | 1 | Input sample valid |
| smp_i_i | input | 12 | In-phase sample, signed |
| smp_q_i | input | 12 | Quadrature sample, signed |
| code_load_i | input | 1 | Shift one reference bit in |
| code_bit_i | input | 1 | Reference bit, 1 means phase π |
| res_valid_o | output | 1 | Result valid |
| res_i_o | output | 17 | In-phase correlation, signed |
| res_q_o | output | 17 | Quadrature correlation, signed |
| res_gate_o | output | 6 | Range-gate index of the result |
| res_last_o | output | 1 | Result is the final gate of the frame |

## Verification
The bench runs every decimation phase, with and without gaps in the sample stream. A design that counted idle cycles, or took the wrong sample in each group of four, would shift every gate value. It loads a true maximal-length code and checks the peak position on a matched echo, which catches a reversed code order or an inverted weight. It drives all-negative and all-positive full-scale inputs under all-plus and all-minus codes, which catches an accumulator one bit too narrow. It also feeds samples during transmit, sends stray transmit-end strobes and aborts a frame midway. A design that leaked samples, restarted without a repetition strobe or kept stale gate counts would then produce extra results, missing results or wrong results.

// File: rtl/pc_corr_pkg.sv
package pc_corr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} seq_st_e;

  function automatic int acc_width(int iq_w, int code_len);
    return iq_w + $clog2(code_len);
  endfunction
endpackage

// File: rtl/pc_decim.sv
module pc_decim #(
  parameter int DEC  = 4,
  localparam int PH_W = $clog2(DEC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            take_o
);
  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= (cnt_q == PH_W'(DEC-1)) ? '0 : cnt_q + 1'b1;
  end

  assign take_o = en_i && (cnt_q == phase_i);

  // at most one symbol per DEC valid samples while phase is steady
  assert_decim_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !clr_i && $stable(phase_i) |=> !take_o || clr_i || !$stable(phase_i));
endmodule

// File: rtl/pc_code_reg.sv
module pc_code_reg #(
  parameter int CODE_LEN = 31
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                bit_i,
  output logic [CODE_LEN-1:0] code_o
);
  // earliest loaded bit ends in the top position (chip 0)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_o <= '0;
    else if (load_i) code_o <= {code_o[CODE_LEN-2:0], bit_i};
  end
endmodule

// File: rtl/pc_corr_line.sv
module pc_corr_line #(
  parameter int IQ_W     = 12,
  parameter int CODE_LEN = 31,
  parameter int ACC_W    = 17
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_i,
  input  logic signed [IQ_W-1:0]  din_i_i,
  input  logic signed [IQ_W-1:0]  din_q_i,
  input  logic [CODE_LEN-1:0]     code_i,
  output logic signed [ACC_W-1:0] sum_i_o,
  output logic signed [ACC_W-1:0] sum_q_o
);
  localparam int LIM = CODE_LEN * (2 ** (IQ_W - 1));

  logic signed [IQ_W-1:0]  dl_i [CODE_LEN];
  logic signed [IQ_W-1:0]  dl_q [CODE_LEN];
  logic signed [ACC_W-1:0] tap_i [CODE_LEN];
  logic signed [ACC_W-1:0] tap_q [CODE_LEN];

  // tap 0 newest; tap j lines up with code bit j
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < CODE_LEN; j++) begin
        dl_i[j] <= '0;
        dl_q[j] <= '0;
      end
    end else if (shift_i) begin
      dl_i[0] <= din_i_i;
      dl_q[0] <= din_q_i;
      for (int j = 1; j < CODE_LEN; j++) begin
        dl_i[j] <= dl_i[j-1];
        dl_q[j] <= dl_q[j-1];
      end
    end
  end

  for (genvar j = 0; j < CODE_LEN; j++) begin : g_tap
    assign tap_i[j] = code_i[j] ? -ACC_W'(dl_i[j]) : ACC_W'(dl_i[j]);
    assign tap_q[j] = code_i[j] ? -ACC_W'(dl_q[j]) : ACC_W'(dl_q[j]);
  end

  always_comb begin
    sum_i_o = '0;
    sum_q_o = '0;
    for (int j = 0; j < CODE_LEN; j++) begin
      sum_i_o = sum_i_o + tap_i[j];
      sum_q_o = sum_q_o + tap_q[j];
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sum_i_o) <= LIM && int'(sum_i_o) >= -LIM &&
    int'(sum_q_o) <= LIM && int'(sum_q_o) >= -LIM);
endmodule

// File: rtl/pc_gate_seq.sv
module pc_gate_seq
  import pc_corr_pkg::*;
#(
  parameter int CODE_LEN  = 31,
  parameter int NUM_GATES = 64,
  localparam int CNT_W  = $clog2(NUM_GATES + CODE_LEN),
  localparam int GATE_W = $clog2(NUM_GATES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pri_i,
  input  logic              tx_end_i,
  input  logic              sym_i,
  output logic              run_o,
  output logic              clr_o,
  output logic              emit_o,
  output logic [GATE_W-1:0] gate_o,
  output logic              last_o
);
  localparam logic [CNT_W-1:0] FILL = CNT_W'(CODE_LEN - 1);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(NUM_GATES + CODE_LEN - 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;

  assign run_o  = (st_q == ST_RUN) && !pri_i;
  assign clr_o  = pri_i || ((st_q == ST_WAIT) && tx_end_i);
  assign emit_o = run_o && sym_i && (cnt_q >= FILL);
  assign gate_o = GATE_W'(cnt_q - FILL);
  assign last_o = emit_o && (gate_o == GATE_W'(NUM_GATES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (pri_i) begin
      st_q  <= ST_WAIT;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_WAIT: if (tx_end_i) begin
          st_q  <= ST_RUN;
          cnt_q <= '0;
        end
        ST_RUN: if (sym_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_o) st_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> (cnt_q < CMAX));
  assert_idle_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (st_q == ST_IDLE) || (st_q == ST_WAIT));
endmodule

// File: rtl/pc_bpsk_corr.sv
module pc_bpsk_corr
  import pc_corr_pkg::*;
#(
  parameter int IQ_W      = 12,
  parameter int CODE_LEN  = 31,
  parameter int NUM_GATES = 64,
  parameter int DEC       = 4,
  localparam int ACC_W  = acc_width(IQ_W, CODE_LEN),
  localparam int GATE_W = $clog2(NUM_GATES),
  localparam int PH_W   = $clog2(DEC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pri_i,
  input  logic                    tx_end_i,
  input  logic [PH_W-1:0]         phase_i,
  input  logic                    smp_valid_i,
  input  logic signed [IQ_W-1:0]  smp_i_i,
  input  logic signed [IQ_W-1:0]  smp_q_i,
  input  logic                    code_load_i,
  input  logic                    code_bit_i,
  output logic                    res_valid_o,
  output logic signed [ACC_W-1:0] res_i_o,
  output logic signed [ACC_W-1:0] res_q_o,
  output logic [GATE_W-1:0]       res_gate_o,
  output logic                    res_last_o
);
  logic                    run, clr, take, emit, last;
  logic [GATE_W-1:0]       gate;
  logic [CODE_LEN-1:0]     code;
  logic signed [ACC_W-1:0] sum_i, sum_q;
  logic                    p_vld, p_last;
  logic [GATE_W-1:0]       p_gate;

  pc_gate_seq #(.CODE_LEN(CODE_LEN), .NUM_GATES(NUM_GATES)) u_seq (
    .clk_i, .rst_ni, .pri_i, .tx_end_i, .sym_i(take),
    .run_o(run), .clr_o(clr), .emit_o(emit), .gate_o(gate), .last_o(last)
  );

  pc_decim #(.DEC(DEC)) u_decim (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(smp_valid_i && run),
    .phase_i, .take_o(take)
  );

  pc_code_reg #(.CODE_LEN(CODE_LEN)) u_code (
    .clk_i, .rst_ni, .load_i(code_load_i), .bit_i(code_bit_i), .code_o(code)
  );

  pc_corr_line #(.IQ_W(IQ_W), .CODE_LEN(CODE_LEN), .ACC_W(ACC_W)) u_line (
    .clk_i, .rst_ni, .shift_i(take), .din_i_i(smp_i_i), .din_q_i(smp_q_i),
    .code_i(code), .sum_i_o(sum_i), .sum_q_o(sum_q)
  );

  // stage 1 tags the symbol, stage 2 samples the settled sum
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld       <= 1'b0;
      p_last      <= 1'b0;
      p_gate      <= '0;
      res_valid_o <= 1'b0;
      res_last_o  <= 1'b0;
      res_gate_o  <= '0;
      res_i_o     <= '0;
      res_q_o     <= '0;
    end else begin
      p_vld       <= emit;
      p_last      <= last;
      p_gate      <= gate;
      res_valid_o <= p_vld && !pri_i;
      res_last_o  <= p_vld && p_last && !pri_i;
      if (p_vld) begin
        res_gate_o <= p_gate;
        res_i_o    <= sum_i;
        res_q_o    <= sum_q;
      end
    end
  end

  assert_abort_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_i |=> !res_valid_o);
  assert_gate_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_gate_o <= GATE_W'(NUM_GATES - 1)));
  assert_last_only_final_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_last_o == (res_gate_o == GATE_W'(NUM_GATES - 1))));
  assert_last_needs_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_last_o |-> res_valid_o);
endmodule

// File: tb/pc_bpsk_corr_tb_top.sv
module pc_bpsk_corr_tb_top;
  localparam int IQ_W = 8;
  localparam int P    = 7;
  localparam int NG   = 12;
  localparam int ACC_W = IQ_W + $clog2(P);
  localparam int GW    = $clog2(NG);
  localparam int NFULL = 4 * (NG + P - 1) + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pri = 1'b0, tx_end = 1'b0, smp_valid = 1'b0, code_load = 1'b0, code_bit = 1'b0;
  logic [1:0] phase = '0;
  logic signed [IQ_W-1:0] smp_i = '0, smp_q = '0;
  logic res_valid, res_last;
  logic signed [ACC_W-1:0] res_i, res_q;
  logic [GW-1:0] res_gate;

  int total = 0, bad = 0;
  bit chips [P];
  logic signed [ACC_W-1:0] got_i [64];
  logic signed [ACC_W-1:0] got_q [64];
  int got_g [64];
  bit got_l [64];
  int n_got = 0;

  always #10 clk = ~clk;

  pc_bpsk_corr #(.IQ_W(IQ_W), .CODE_LEN(P), .NUM_GATES(NG), .DEC(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pri_i(pri), .tx_end_i(tx_end), .phase_i(phase),
    .smp_valid_i(smp_valid), .smp_i_i(smp_i), .smp_q_i(smp_q),
    .code_load_i(code_load), .code_bit_i(code_bit),
    .res_valid_o(res_valid), .res_i_o(res_i), .res_q_o(res_q),
    .res_gate_o(res_gate), .res_last_o(res_last)
  );

  always @(negedge clk) begin
    if (rst_n && res_valid && n_got < 64) begin
      got_i[n_got] = res_i;
      got_q[n_got] = res_q;
      got_g[n_got] = int'(res_gate);
      got_l[n_got] = res_last;
      n_got++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sval(int n, int seed, int mode);
    int m;
    case (mode)
      0: return ((n * 37 + seed * 53 + (n * n) % 17) % 256) - 128;
      1: return -128;
      2: return 127;
      default: begin
        m = n / 4;
        if (m >= 3 && m < 3 + P) return chips[m-3] ? -100 : 100;
        return 0;
      end
    endcase
  endfunction

  function automatic int expect_gate(int g, int ph, int seed, int mode);
    int acc = 0;
    for (int k = 0; k < P; k++)
      acc += (chips[k] ? -1 : 1) * sval(4 * (g + k) + ph, seed, mode);
    return acc;
  endfunction

  task automatic load_code();
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      code_load = 1'b1;
      code_bit  = chips[k];
    end
    @(negedge clk);
    code_load = 1'b0;
  endtask

  task automatic drive_frame(input int ph, input int mode, input bit gaps, input int nsamp);
    @(negedge clk);
    phase = 2'(ph);
    pri = 1'b1;
    @(negedge clk);
    pri = 1'b0;
    // samples during transmit must be ignored (R3)
    for (int j = 0; j < 3; j++) begin
      smp_valid = 1'b1; smp_i = 8'sd99; smp_q = -8'sd99;
      @(negedge clk);
    end
    smp_valid = 1'b0;
    tx_end = 1'b1;
    @(negedge clk);
    tx_end = 1'b0;
    for (int n = 0; n < nsamp; n++) begin
      if (gaps && (n % 3 == 1)) begin
        smp_valid = 1'b0; smp_i = 8'sd55; smp_q = 8'sd55;
        @(negedge clk);
      end
      smp_valid = 1'b1;
      smp_i = IQ_W'(sval(n, 1, mode));
      smp_q = IQ_W'(sval(n, 2, mode));
      @(negedge clk);
    end
    smp_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_frame(input int ph, input int mode, input string tag);
    int ei, eq;
    chk(n_got == NG, {tag, " R6 result count"}, n_got, NG);
    for (int g = 0; g < NG && g < n_got; g++) begin
      ei = expect_gate(g, ph, 1, mode);
      eq = expect_gate(g, ph, 2, mode);
      chk(got_g[g] == g, {tag, " R6 gate order"}, got_g[g], g);
      chk(got_l[g] == (g == NG - 1), {tag, " R7 last flag"}, got_l[g], g == NG - 1);
      chk(int'(got_i[g]) == ei, {tag, " R5 I value"}, got_i[g], ei);
      chk(int'(got_q[g]) == eq, {tag, " R5 Q value"}, got_q[g], eq);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0 && res_last == 1'b0, "R1 flags in reset", res_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0 && res_gate == '0, "R1 flags after reset", res_valid, 0);
    chk(res_i == '0 && res_q == '0, "R1 data after reset", res_i, 0);

    // maximal-length code, chip 0 first
    chips = '{1, 1, 1, 0, 0, 1, 0};
    load_code();

    // R4: every decimation phase, with and without gaps
    for (int ph = 0; ph < 4; ph++) begin
      n_got = 0;
      drive_frame(ph, 0, ph[0], NFULL);
      check_frame(ph, 0, $sformatf("R4 phase%0d", ph));
    end

    // R2: matched echo peaks at its start gate
    n_got = 0;
    drive_frame(2, 3, 1'b0, NFULL);
    check_frame(2, 3, "R2 echo");
    chk(n_got > 3 && int'(got_i[3]) == 700, "R2 peak value gate 3", got_i[3], 700);

    // R3 / R7: stray tx_end after frame end yields nothing
    n_got = 0;
    @(negedge clk);
    tx_end = 1'b1;
    @(negedge clk);
    tx_end = 1'b0;
    for (int n = 0; n < 100; n++) begin
      smp_valid = 1'b1; smp_i = IQ_W'(n); smp_q = IQ_W'(n);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_got == 0, "R3 tx_end without pri ignored", n_got, 0);

    // R8: abort mid-frame, then a clean frame
    n_got = 0;
    drive_frame(1, 0, 1'b0, 4 * (P + 2));
    chk(n_got == 3, "R8 partial results before abort", n_got, 3);
    n_got = 0;
    drive_frame(3, 0, 1'b1, NFULL);
    check_frame(3, 0, "R8 after abort");

    // R5: full-scale extremes under all-plus and all-minus codes
    chips = '{0, 0, 0, 0, 0, 0, 0};
    load_code();
    n_got = 0;
    drive_frame(0, 1, 1'b0, NFULL);
    check_frame(0, 1, "R5 neg plus");
    chk(n_got > 0 && int'(got_i[0]) == -896, "R5 min value", got_i[0], -896);
    n_got = 0;
    drive_frame(1, 2, 1'b0, NFULL);
    check_frame(1, 2, "R5 pos plus");
    chips = '{1, 1, 1, 1, 1, 1, 1};
    load_code();
    n_got = 0;
    drive_frame(2, 1, 1'b0, NFULL);
    check_frame(2, 1, "R5 neg minus");
    chk(n_got > 0 && int'(got_i[0]) == 896, "R5 max value", got_i[0], 896);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule